// File: doc/BRIEF.md
# Weighted Round-Robin Link Scheduler

This block decides which of several virtual-channel buffers may drive a shared physical link. Each channel has a programmable weight. Once a channel holds the grant, it keeps it until it has moved as many words as its weight allows, or until its buffer runs dry. The grant then passes to the next eligible channel in ascending index order. When no eligible channel remains above the last one served, the round closes. A one-cycle pulse marks the round boundary, and the search starts again from channel 0 in the same decision. No cycle is lost.

The requests are the buffers' non-empty flags. The word strobe comes from the link each time a word is taken. Weights are written through a small write-only port into a pending copy. The scheduler only uses an active copy, which is refreshed from the pending copy at round boundaries. A weight change therefore never cuts a round in half. A weight of zero removes a channel from the rotation. With W as the sum of the active weights, a channel that keeps requesting gets a turn within about W words of link traffic.

Top module: `wrr_vc_sched`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `grant` is all zeros and `round_pulse` is low. The rotation position is channel 0. Every pending and active weight equals `DEF_WGT`.
- R2: `grant` is one-hot or zero. A bit rises only for a channel whose `req` was high in the previous cycle, so the grant has one cycle of registered latency.
- R3: A granted channel keeps the grant until `word_acc` has been seen high on as many cycles as its active weight. The word count restarts at zero with every new grant, and the grant moves on the clock edge after the last counted word.
- R4: When the grant is released, the next grant goes to the lowest-index eligible channel above the channel last served in this round. It is issued on the same edge as the release, with no idle cycle.
- R5: If the granted channel's `req` is low, the grant is withdrawn at the next edge, even if fewer words than the weight have moved.
- R6: When a release finds no eligible channel above the last one served, the round ends. `round_pulse` is high for that one cycle (only if a round was in progress), and the next grant is chosen from channel 0 upward.
- R7: A channel whose active weight is 0 is never granted.
- R8: A write with `cfg_we` high stores `cfg_wgt` as the pending weight of channel `cfg_ch`. That value becomes active only at a round boundary (a wrap, or a decision with nothing to grant) that happens after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req | input | N | Per-channel buffer non-empty flag |
| word_acc | input | 1 | Link took one word from the granted channel this cycle |
| cfg_we | input | 1 | Pending-weight write strobe |
| cfg_ch | input | $clog2(N) | Channel whose pending weight is written |
| cfg_wgt | input | WW | Weight value to write |
| grant | output | N | One-hot link grant, registered |
| round_pulse | output | 1 | One-cycle round-boundary marker, registered |

## Verification
The hardest case to reach from the ports is a weight write that lands in the middle of a round. It must not change the current round, and it must apply exactly at the next wrap. The same goes for a wrap that happens on the same edge as a write, where the old pending value has to win. The stimulus programs weights while the link is busy, then keeps all requests high so that wraps come at a known rate. Random traffic then drops requests in the middle of a turn, which forces early releases, idle decisions and back-to-back wraps. Every grant and pulse is compared cycle by cycle against a model of the requirements.

// File: rtl/wrr_pkg.sv
`timescale 1ns/1ps
package wrr_pkg;
  // Outcome of one scheduling decision
  typedef enum logic [1:0] {
    DEC_HOLD = 2'd0,  // current holder keeps the link
    DEC_NEXT = 2'd1,  // pass to a later channel in this round
    DEC_WRAP = 2'd2,  // round closes, next grant from channel 0
    DEC_IDLE = 2'd3   // round closes, nobody eligible
  } dec_e;
endpackage

// File: rtl/wrr_weight_bank.sv
`timescale 1ns/1ps
module wrr_weight_bank #(
  parameter int N       = 4,
  parameter int WW      = 4,
  parameter int DEF_WGT = 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [$clog2(N)-1:0] wr_ch,
  input  logic [WW-1:0]        wr_val,
  input  logic                 load,
  output logic [N*WW-1:0]      pend_flat,
  output logic [N*WW-1:0]      act_flat
);
  localparam logic [WW-1:0] RST_W = WW'(DEF_WGT);

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_ch
      logic [WW-1:0] pend_q;
      logic [WW-1:0] act_q;

      always_ff @(posedge clk) begin
        if (rst) begin
          pend_q <= RST_W;
          act_q  <= RST_W;
        end else begin
          if (load)
            act_q <= pend_q;
          if (wr_en && (int'(wr_ch) == g))
            pend_q <= wr_val;
        end
      end

      assign pend_flat[g*WW +: WW] = pend_q;
      assign act_flat[g*WW +: WW]  = act_q;
    end
  endgenerate
endmodule

// File: rtl/wrr_pick.sv
`timescale 1ns/1ps
module wrr_pick #(
  parameter int N  = 4,
  parameter int PW = 3,
  parameter int IW = 2
) (
  input  logic [N-1:0]  elig,
  input  logic [PW-1:0] start,
  output logic          hit,
  output logic [IW-1:0] idx
);
  // lowest eligible index at or above start
  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (elig[i] && (i >= int'(start))) begin
        hit = 1'b1;
        idx = IW'(i);
      end
    end
  end
endmodule

// File: rtl/wrr_quota.sv
`timescale 1ns/1ps
module wrr_quota #(
  parameter int WW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          holding,
  input  logic          fresh,
  input  logic          req_cur,
  input  logic          word_acc,
  input  logic [WW-1:0] wgt_cur,
  output logic          release_o
);
  logic [WW-1:0] used_q;
  logic [WW:0]   used_inc;

  assign used_inc  = {1'b0, used_q} + {{WW{1'b0}}, 1'b1};
  assign release_o = !holding || !req_cur ||
                     (word_acc && (used_inc >= {1'b0, wgt_cur}));

  always_ff @(posedge clk) begin
    if (rst)
      used_q <= '0;
    else if (fresh)
      used_q <= '0;
    else if (holding && word_acc)
      used_q <= used_inc[WW-1:0];
  end
endmodule

// File: rtl/wrr_vc_sched.sv
`timescale 1ns/1ps
module wrr_vc_sched #(
  parameter int N       = 4,
  parameter int WW      = 4,
  parameter int DEF_WGT = 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [N-1:0]         req,
  input  logic                 word_acc,
  input  logic                 cfg_we,
  input  logic [$clog2(N)-1:0] cfg_ch,
  input  logic [WW-1:0]        cfg_wgt,
  output logic [N-1:0]         grant,
  output logic                 round_pulse
);
  import wrr_pkg::*;

  localparam int IW = $clog2(N);
  localparam int PW = $clog2(N + 1);

  logic [N*WW-1:0] w_act_flat;
  logic [N*WW-1:0] w_pend_flat;
  logic [N-1:0]    el_act;
  logic [N-1:0]    el_pend;
  logic [PW-1:0]   pos_q;
  logic [IW-1:0]   cur_q;
  logic            vld_q;
  logic [N-1:0]    gnt_q;
  logic            pulse_q;
  logic            hit_c, hit_w;
  logic [IW-1:0]   idx_c, idx_w;
  logic            rel;
  logic            load_w;
  logic            fresh;
  logic [WW-1:0]   wgt_cur;
  dec_e            dec;

  wrr_weight_bank #(.N(N), .WW(WW), .DEF_WGT(DEF_WGT)) u_bank (
    .clk(clk), .rst(rst),
    .wr_en(cfg_we), .wr_ch(cfg_ch), .wr_val(cfg_wgt),
    .load(load_w),
    .pend_flat(w_pend_flat), .act_flat(w_act_flat)
  );

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_elig
      assign el_act[g]  = req[g] && (w_act_flat[g*WW +: WW] != '0);
      assign el_pend[g] = req[g] && (w_pend_flat[g*WW +: WW] != '0);
    end
  endgenerate

  // search within the running round, using the active weights
  wrr_pick #(.N(N), .PW(PW), .IW(IW)) u_pick_cur (
    .elig(el_act), .start(pos_q), .hit(hit_c), .idx(idx_c)
  );

  // search of a fresh round, using the weights that will load
  wrr_pick #(.N(N), .PW(PW), .IW(IW)) u_pick_wrap (
    .elig(el_pend), .start(PW'(0)), .hit(hit_w), .idx(idx_w)
  );

  assign wgt_cur = w_act_flat[cur_q*WW +: WW];

  wrr_quota #(.WW(WW)) u_quota (
    .clk(clk), .rst(rst),
    .holding(vld_q), .fresh(fresh),
    .req_cur(req[cur_q]), .word_acc(word_acc),
    .wgt_cur(wgt_cur), .release_o(rel)
  );

  always_comb begin
    if (!rel)       dec = DEC_HOLD;
    else if (hit_c) dec = DEC_NEXT;
    else if (hit_w) dec = DEC_WRAP;
    else            dec = DEC_IDLE;
  end

  assign load_w = (dec == DEC_WRAP) || (dec == DEC_IDLE);
  assign fresh  = (dec == DEC_NEXT) || (dec == DEC_WRAP);

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q   <= '0;
      cur_q   <= '0;
      vld_q   <= 1'b0;
      gnt_q   <= '0;
      pulse_q <= 1'b0;
    end else begin
      unique case (dec)
        DEC_HOLD: begin
          pulse_q <= 1'b0;
        end
        DEC_NEXT: begin
          cur_q   <= idx_c;
          vld_q   <= 1'b1;
          gnt_q   <= N'(1) << idx_c;
          pos_q   <= PW'(idx_c) + PW'(1);
          pulse_q <= 1'b0;
        end
        DEC_WRAP: begin
          cur_q   <= idx_w;
          vld_q   <= 1'b1;
          gnt_q   <= N'(1) << idx_w;
          pos_q   <= PW'(idx_w) + PW'(1);
          pulse_q <= (pos_q != '0);
        end
        default: begin
          vld_q   <= 1'b0;
          gnt_q   <= '0;
          pos_q   <= '0;
          pulse_q <= (pos_q != '0);
        end
      endcase
    end
  end

  assign grant       = gnt_q;
  assign round_pulse = pulse_q;
endmodule

// File: rtl/wrr_vc_sched_chk.sv
`timescale 1ns/1ps
module wrr_vc_sched_chk #(
  parameter int N  = 4,
  parameter int WW = 4
) (
  input logic            clk,
  input logic            rst,
  input logic [N-1:0]    req,
  input logic            word_acc,
  input logic [N-1:0]    grant,
  input logic            round_pulse,
  input logic [N*WW-1:0] w_act_flat
);
  logic [N-1:0] prev_gnt;
  logic [WW:0]  acc_q;
  logic [WW:0]  base;
  logic [WW:0]  total;
  logic [WW-1:0] gw;

  always_comb begin
    gw = '0;
    for (int i = 0; i < N; i++)
      if (grant[i]) gw = w_act_flat[i*WW +: WW];
  end

  assign base  = ((grant != prev_gnt) || round_pulse) ? '0 : acc_q;
  assign total = base + {{WW{1'b0}}, (word_acc && (|grant))};

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_gnt <= '0;
      acc_q    <= '0;
    end else begin
      prev_gnt <= grant;
      acc_q    <= total;
    end
  end

  AST_RST_CLEAR: assert property (@(posedge clk)
    rst |=> (grant == '0 && !round_pulse)); // R1

  AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant)); // R2

  AST_GNT_HAD_REQ: assert property (@(posedge clk) disable iff (rst)
    (|grant) |-> (|(grant & $past(req)))); // R2

  AST_WORD_QUOTA: assert property (@(posedge clk) disable iff (rst)
    (|grant) |-> (total <= {1'b0, gw})); // R3

  AST_ZERO_WGT_SKIP: assert property (@(posedge clk) disable iff (rst)
    (|grant) |-> (gw != '0)); // R7
endmodule

bind wrr_vc_sched wrr_vc_sched_chk #(.N(N), .WW(WW)) u_chk (
  .clk(clk), .rst(rst), .req(req), .word_acc(word_acc),
  .grant(grant), .round_pulse(round_pulse), .w_act_flat(w_act_flat)
);

// File: tb/sim_wrr_vc_sched.sv
`timescale 1ns/1ps
module sim_wrr_vc_sched;
  localparam int N  = 4;
  localparam int WW = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [N-1:0]  req = '0;
  logic          word_acc = 1'b0;
  logic          cfg_we = 1'b0;
  logic [1:0]    cfg_ch = '0;
  logic [WW-1:0] cfg_wgt = '0;
  logic [N-1:0]  grant;
  logic          round_pulse;

  int checks = 0;
  int fails  = 0;
  string tag = "R1";

  // requirement model state
  int          mpos, mcur, mcnt;
  bit          mvalid, epulse;
  logic [N-1:0] egnt;
  logic [WW-1:0] mact [N];
  logic [WW-1:0] mpend [N];

  always #4 clk = ~clk;  // 125 MHz

  wrr_vc_sched #(.N(N), .WW(WW), .DEF_WGT(1)) u0 (
    .clk(clk), .rst(rst), .req(req), .word_acc(word_acc),
    .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_wgt(cfg_wgt),
    .grant(grant), .round_pulse(round_pulse)
  );

  task automatic model_reset();
    mpos = 0; mcur = 0; mcnt = 0; mvalid = 0; epulse = 0; egnt = '0;
    for (int i = 0; i < N; i++) begin mact[i] = 4'd1; mpend[i] = 4'd1; end
  endtask

  task automatic model_step(input logic [N-1:0] r, input bit a,
                            input bit we, input int ch, input logic [WW-1:0] w);
    bit rel, found;
    rel = !mvalid || !r[mcur] || (a && (mcnt + 1 >= int'(mact[mcur])));
    epulse = 0;
    if (!rel) begin
      if (a) mcnt++;
    end else begin
      found = 0;
      for (int j = mpos; j < N; j++)
        if (!found && r[j] && mact[j] != 0) begin
          found = 1; mcur = j; mcnt = 0; mvalid = 1; mpos = j + 1;
        end
      if (!found) begin  // R6 round boundary, R8 weights load
        epulse = (mpos != 0);
        for (int j = 0; j < N; j++) mact[j] = mpend[j];
        for (int j = 0; j < N; j++)
          if (!found && r[j] && mact[j] != 0) begin
            found = 1; mcur = j; mcnt = 0; mvalid = 1; mpos = j + 1;
          end
        if (!found) begin mvalid = 0; mpos = 0; end
      end
    end
    egnt = mvalid ? (N'(1) << mcur) : '0;
    if (we) mpend[ch] = w;
  endtask

  task automatic check(input string what, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
    end
  endtask

  // one cycle: drive at negedge, compare after the edge at next negedge
  task automatic cyc(input logic [N-1:0] r, input bit a,
                     input bit we = 0, input int ch = 0, input logic [WW-1:0] w = '0);
    req = r; word_acc = a; cfg_we = we; cfg_ch = 2'(ch); cfg_wgt = w;
    model_step(r, a, we, ch, w);
    @(negedge clk);
    check("grant", grant, egnt);
    check("round_pulse", {{(N-1){1'b0}}, round_pulse}, {{(N-1){1'b0}}, epulse});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [N-1:0] rr;
    void'($urandom(32'h5eed_1234));
    model_reset();
    repeat (3) @(negedge clk);
    // R1: reset state
    tag = "R1";
    check("grant in reset", grant, '0);
    check("pulse in reset", {{(N-1){1'b0}}, round_pulse}, '0);
    rst = 1'b0;
    // R1: default weights give one word each, ascending from 0
    for (int k = 0; k < 10; k++) cyc(4'b1111, 1'b1);

    // R8: program weights while busy; old weights hold until wrap
    tag = "R8";
    cyc(4'b1111, 1'b1, 1, 0, 4'd3);
    cyc(4'b1111, 1'b1, 1, 1, 4'd1);
    cyc(4'b1111, 1'b1, 1, 2, 4'd0);
    cyc(4'b1111, 1'b1, 1, 3, 4'd2);
    for (int k = 0; k < 6; k++) cyc(4'b1111, 1'b1);

    // R3 R4 R6 R7: steady full load, quota per channel, channel 2 skipped
    tag = "R3_R4_R6_R7";
    for (int k = 0; k < 30; k++) cyc(4'b1111, 1'b1);
    // R3: link stalls do not consume quota
    for (int k = 0; k < 20; k++) cyc(4'b1111, (k % 3) == 0);

    // R5: holder's request drops mid-turn
    tag = "R5";
    cyc(4'b0000, 1'b0);
    cyc(4'b0000, 1'b0);
    cyc(4'b0001, 1'b0);
    cyc(4'b0001, 1'b1);
    cyc(4'b1000, 1'b0);
    cyc(4'b1000, 1'b1);
    cyc(4'b1001, 1'b1);
    cyc(4'b0000, 1'b0);

    // R8: write on the same edge as a wrap keeps the old pending value
    tag = "R8";
    for (int k = 0; k < 12; k++)
      cyc(4'b1011, 1'b1, (k == 5), 1, 4'd4);
    for (int k = 0; k < 12; k++) cyc(4'b1011, 1'b1);

    // R2: constrained random traffic with sticky requests and rare writes
    tag = "R2";
    rr = 4'b0101;
    for (int k = 0; k < 3000; k++) begin
      for (int i = 0; i < N; i++)
        if (($urandom % 8) == 0) rr[i] = ~rr[i];
      if (($urandom % 40) == 0)
        cyc(rr, ($urandom % 4) != 0, 1, int'($urandom % N), 4'($urandom % 5));
      else
        cyc(rr, ($urandom % 4) != 0);
    end

    // R7: all weights zero -> nothing granted
    tag = "R7";
    for (int i = 0; i < N; i++) cyc(4'b0000, 1'b0, 1, i, 4'd0);
    for (int k = 0; k < 8; k++) cyc(4'b1111, 1'b1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule